// File: doc/BRIEF.md
# Display FIFO refill timing calculator

This block computes the two refill thresholds of a display FIFO and the number of memory clocks that one FIFO word takes. It takes the memory and pixel clock divider settings, the pixel depth, the FIFO depth, the memory access delays and a loop latency. It returns two packed 32-bit configuration words. A one-cycle `start` pulse latches all operands. A one-cycle `done` pulse then marks the point where both words are valid.

The arithmetic runs as a fixed-point procedure in a fixed order. The block first forms a rate ratio from the dividers and cancels the common powers of two. It then picks a precision from the size of the FIFO drain time and derives the off threshold. The on threshold is raised to cover the memory delays, rounded to a step that depends on the precision, and pulled below the off threshold when it would reach it. One shared serial divider does all the divisions, one after another.

Top module: `dft_calc`

## Requirements
- R1: During reset and after reset, with no start accepted yet, `done` is 0 and `word_a` and `word_b` are 0.
- R2: A `start` seen while the block is idle latches every operand. Exactly one `done` pulse follows, one cycle wide. Both words change only in the `done` cycle and hold their values until the next `done`.
- R3: A `start` that arrives while a calculation is running has no effect. It produces no extra `done`, and the result still reflects the operands latched first.
- R4: The ratio is M = mem_fb_div × pix_post_real and D = pix_fb_div × mem_ref_div. When pix_bpp ≥ 8, D is also multiplied by pix_bpp/4. Both M and D are halved for as long as both are even.
- R5: The base shift S is 4 − mem_post_code. It is one lower again when pix_bpp is 0.
- R6: Let T = floor((M × fifo_depth × 2^S) / D). The precision P is (bit length of T) − 5, clamped to 0..7. P sits in word_b bits 22:20. Let X = 6 − P. A shift by X or by S+X that comes out negative (−1) is a one-place right shift.
- R7: off = floor((M × (fifo_depth−1) × 2^(S+X)) / D) − 2^S. It sits in word_a bits 15:0.
- R8: Let on0 = floor((M × 2^(S+X) + D)/D) and r = ras_delay shifted by X, plus 1. Then on = max(on0, r) + 2r + (page_delay shifted by X). This value is rounded up to a multiple of the step: 2^(6−P) for P ≤ 5, and 1 otherwise. It sits in word_a bits 31:16.
- R9: Compare the rounded on with off rounded down to a multiple of the step. If on is greater than or equal to it, on is replaced by off − (on0 − 1), rounded down to a multiple of the step.
- R10: word_b bits 15:0 hold floor((M × 2^(S+X+5) + D)/D). Bits 19:16 hold the latched loop_latency, and bits 31:23 are 0.
- R11: `done` arrives no more than 240 cycles after the clock edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Pulse that begins a calculation when idle |
| mem_fb_div | input | 8 | Memory clock feedback divider |
| pix_fb_div | input | 8 | Pixel clock feedback divider |
| pix_post_real | input | 4 | Real pixel post divider value (1 to 12) |
| mem_ref_div | input | 2 | Memory reference divider (1 or 3) |
| mem_post_code | input | 2 | Memory post-divider code |
| pix_bpp | input | 6 | Bits per pixel, 0 meaning the 32-bit-word text mode |
| fifo_depth | input | 6 | Display FIFO depth in words |
| ras_delay | input | 5 | Row-access delay in memory clocks |
| page_delay | input | 5 | Page-fault delay in memory clocks |
| loop_latency | input | 4 | Loop latency copied into word_b |
| done | output | 1 | One-cycle pulse: both words valid |
| word_a | output | 32 | On threshold (31:16) and off threshold (15:0) |
| word_b | output | 32 | Precision, loop latency and clocks per word |

## Verification
The assertions take the operands to be sensible divider settings. They assume M and D are non-zero, that S does not go below zero, and that the fifo depth is at least 2. They also assume that both thresholds and the clocks-per-word value fit in 16 bits and never go negative; that assumption is what makes the on ≤ off and the nonzero-clocks properties hold. The bench computes every case in its own wide signed model first and applies only the cases that meet these bounds. It covers precision 0, middle precisions and the clamp at 7, and both the rounding path and the fall-back path for the on threshold.

// File: rtl/dft_pkg.sv
`timescale 1ns/1ps
package dft_pkg;
   localparam int WORD_W     = 32;
   localparam int HALF_W     = 16;
   localparam int LAT_W      = 4;
   localparam int PREC_W     = 3;
   localparam int PREC_LSB   = 20;
   localparam int PREC_MAX   = 7;
   localparam int BASE_XS    = 6;
   localparam int BASE_SHIFT = 4;
   localparam int XCLK_EXTRA = 5;
   localparam int SH_W       = 6;

   typedef enum logic [2:0] {
      ST_IDLE, ST_REDUCE, ST_LAUNCH, ST_WAIT, ST_FINAL
   } seq_st_t;

   typedef enum logic [1:0] {
      PH_T, PH_OFF, PH_ON, PH_XCLK
   } div_ph_t;

   // shift by a two's complement amount: negative values shift right
   function automatic logic [63:0] shl_tc(input logic [63:0] v, input logic [SH_W-1:0] a);
      logic [SH_W-1:0] mag;
      mag = -a;
      if (a[SH_W-1]) return v >> mag;
      else           return v << a;
   endfunction
endpackage

// File: rtl/dft_sdiv.sv
`timescale 1ns/1ps
module dft_sdiv #(
   parameter int NUM_W = 48,
   parameter int DEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo,
   output logic             fin
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem_r, den_r;
   logic [NUM_W-1:0] q_r;
   logic [CNT_W-1:0] cnt_r;
   logic             run_r;
   logic [DEN_W:0]   trial, diff;
   logic             take;

   always_comb begin
      trial = {rem_r, q_r[NUM_W-1]};
      diff  = trial - {1'b0, den_r};
      take  = (trial >= {1'b0, den_r});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_r <= '0;
         den_r <= '0;
         q_r   <= '0;
         cnt_r <= '0;
         run_r <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go && !run_r) begin
            q_r   <= num;
            den_r <= den;
            rem_r <= '0;
            cnt_r <= CNT_W'(NUM_W);
            run_r <= 1'b1;
         end else if (run_r) begin
            rem_r <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            q_r   <= {q_r[NUM_W-2:0], take};
            cnt_r <= cnt_r - CNT_W'(1);
            if (cnt_r == CNT_W'(1)) begin
               run_r <= 1'b0;
               fin   <= 1'b1;
            end
         end
      end
   end

   assign quo = q_r;
endmodule

// File: rtl/dft_prec_pick.sv
`timescale 1ns/1ps
module dft_prec_pick import dft_pkg::*; #(
   parameter int NUM_W = 48
) (
   input  logic [NUM_W-1:0]  drain,
   output logic [PREC_W-1:0] prec
);
   int blen;
   int p;

   always_comb begin
      blen = 0;
      for (int i = 0; i < NUM_W; i++) begin
         if (drain[i]) blen = i + 1;
      end
      p = blen - 5;
      if (p < 0)             prec = '0;
      else if (p > PREC_MAX) prec = PREC_W'(PREC_MAX);
      else                   prec = PREC_W'(p);
   end
endmodule

// File: rtl/dft_on_shape.sv
`timescale 1ns/1ps
module dft_on_shape import dft_pkg::*; #(
   parameter int W     = 32,
   parameter int DLY_W = 5
) (
   input  logic [W-1:0]      on_q,
   input  logic [W-1:0]      off,
   input  logic [PREC_W-1:0] prec,
   input  logic [DLY_W-1:0]  ras,
   input  logic [DLY_W-1:0]  pf,
   output logic [W-1:0]      on_fin
);
   logic [SH_W-1:0] xs;
   logic [W-1:0]    r, pfs, on1, on2, on3, mask, offd, fall;

   always_comb begin
      xs   = SH_W'(BASE_XS) - SH_W'(prec);
      r    = W'(shl_tc(64'(ras), xs)) + W'(1);
      pfs  = W'(shl_tc(64'(pf), xs));
      on1  = (on_q < r) ? r : on_q;
      on2  = on1 + (r << 1) + pfs;
      if (prec >= PREC_W'(BASE_XS)) mask = '0;
      else                          mask = (W'(1) << (PREC_W'(BASE_XS) - prec)) - W'(1);
      on3  = (on2 + mask) & ~mask;
      offd = off & ~mask;
      fall = (off - (on_q - W'(1))) & ~mask;
      on_fin = (on3 >= offd) ? fall : on3;
   end
endmodule

// File: rtl/dft_calc.sv
`timescale 1ns/1ps
module dft_calc import dft_pkg::*; #(
   parameter int FB_W   = 8,
   parameter int PD_W   = 4,
   parameter int XR_W   = 2,
   parameter int CODE_W = 2,
   parameter int BPP_W  = 6,
   parameter int FIFO_W = 6,
   parameter int DLY_W  = 5,
   parameter int NUM_W  = 48,
   parameter int DEN_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FB_W-1:0]   mem_fb_div,
   input  logic [FB_W-1:0]   pix_fb_div,
   input  logic [PD_W-1:0]   pix_post_real,
   input  logic [XR_W-1:0]   mem_ref_div,
   input  logic [CODE_W-1:0] mem_post_code,
   input  logic [BPP_W-1:0]  pix_bpp,
   input  logic [FIFO_W-1:0] fifo_depth,
   input  logic [DLY_W-1:0]  ras_delay,
   input  logic [DLY_W-1:0]  page_delay,
   input  logic [LAT_W-1:0]  loop_latency,
   output logic              done,
   output logic [WORD_W-1:0] word_a,
   output logic [WORD_W-1:0] word_b
);
   localparam int MUL_W  = FB_W + PD_W;
   localparam int SDEN_W = FB_W + XR_W + BPP_W;

   initial begin
      assert (NUM_W <= 64 && NUM_W > DEN_W) else $error("NUM_W must exceed DEN_W and stay within 64");
      assert (DEN_W >= SDEN_W && DEN_W >= WORD_W) else $error("DEN_W too narrow for the scaled divider");
      assert (CODE_W <= 2) else $error("post-divider code wider than the base shift allows");
   end

   seq_st_t            st;
   div_ph_t            ph;
   logic [MUL_W-1:0]   m_r;
   logic [DEN_W-1:0]   d_r;
   logic [SH_W-1:0]    s0_r;
   logic [FIFO_W-1:0]  fifo_r;
   logic [DLY_W-1:0]   ras_r, pf_r;
   logic [LAT_W-1:0]   lat_r;
   logic [PREC_W-1:0]  prec_r;
   logic [DEN_W-1:0]   off_r, onq_r, xclk_r;

   logic [BPP_W-1:0]   bpp_fac;
   logic [SDEN_W-1:0]  den_calc;
   logic [SH_W-1:0]    s0_calc, xs, sh2;
   logic [NUM_W-1:0]   dv_num, dv_quo;
   logic               dv_go, dv_fin, seq_wait;
   logic [PREC_W-1:0]  prec_new;
   logic [DEN_W-1:0]   on_fin;

   always_comb begin
      bpp_fac  = (pix_bpp >= BPP_W'(8)) ? (pix_bpp >> 2) : BPP_W'(1);
      den_calc = SDEN_W'(pix_fb_div) * SDEN_W'(mem_ref_div) * SDEN_W'(bpp_fac);
      s0_calc  = SH_W'(BASE_SHIFT) - SH_W'(mem_post_code) - SH_W'(pix_bpp == '0);
      xs       = SH_W'(BASE_XS) - SH_W'(prec_r);
      sh2      = s0_r + xs;
   end

   always_comb begin
      case (ph)
         PH_T:    dv_num = NUM_W'(shl_tc(64'(m_r) * 64'(fifo_r), s0_r));
         PH_OFF:  dv_num = NUM_W'(shl_tc(64'(m_r) * 64'(fifo_r - FIFO_W'(1)), sh2));
         PH_ON:   dv_num = NUM_W'(shl_tc(64'(m_r), sh2) + 64'(d_r));
         default: dv_num = NUM_W'(shl_tc(64'(m_r), sh2 + SH_W'(XCLK_EXTRA)) + 64'(d_r));
      endcase
   end

   assign dv_go    = (st == ST_LAUNCH);
   assign seq_wait = (st == ST_WAIT);

   dft_sdiv #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(dv_go), .num(dv_num), .den(d_r),
      .quo(dv_quo), .fin(dv_fin)
   );

   dft_prec_pick #(.NUM_W(NUM_W)) u_prec (
      .drain(dv_quo), .prec(prec_new)
   );

   dft_on_shape #(.W(DEN_W), .DLY_W(DLY_W)) u_shape (
      .on_q(onq_r), .off(off_r), .prec(prec_r), .ras(ras_r), .pf(pf_r),
      .on_fin(on_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph     <= PH_T;
         m_r    <= '0;
         d_r    <= '0;
         s0_r   <= '0;
         fifo_r <= '0;
         ras_r  <= '0;
         pf_r   <= '0;
         lat_r  <= '0;
         prec_r <= '0;
         off_r  <= '0;
         onq_r  <= '0;
         xclk_r <= '0;
         done   <= 1'b0;
         word_a <= '0;
         word_b <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  m_r    <= MUL_W'(mem_fb_div) * MUL_W'(pix_post_real);
                  d_r    <= DEN_W'(den_calc);
                  s0_r   <= s0_calc;
                  fifo_r <= fifo_depth;
                  ras_r  <= ras_delay;
                  pf_r   <= page_delay;
                  lat_r  <= loop_latency;
                  st     <= ST_REDUCE;
               end
            end
            ST_REDUCE: begin
               if (!m_r[0] && !d_r[0] && (m_r != '0)) begin
                  m_r <= m_r >> 1;
                  d_r <= d_r >> 1;
               end else begin
                  ph <= PH_T;
                  st <= ST_LAUNCH;
               end
            end
            ST_LAUNCH: st <= ST_WAIT;
            ST_WAIT: begin
               if (dv_fin) begin
                  st <= ST_LAUNCH;
                  case (ph)
                     PH_T: begin
                        prec_r <= prec_new;
                        ph     <= PH_OFF;
                     end
                     PH_OFF: begin
                        off_r <= DEN_W'(dv_quo) - (DEN_W'(1) << s0_r);
                        ph    <= PH_ON;
                     end
                     PH_ON: begin
                        onq_r <= DEN_W'(dv_quo);
                        ph    <= PH_XCLK;
                     end
                     default: begin
                        xclk_r <= DEN_W'(dv_quo);
                        st     <= ST_FINAL;
                     end
                  endcase
               end
            end
            ST_FINAL: begin
               word_a <= {on_fin[HALF_W-1:0], off_r[HALF_W-1:0]};
               word_b <= {{(WORD_W-PREC_LSB-PREC_W){1'b0}}, prec_r, lat_r, xclk_r[HALF_W-1:0]};
               done   <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dft_calc_chk.sv
`timescale 1ns/1ps
module dft_calc_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        done,
   input logic [31:0] word_a,
   input logic [31:0] word_b,
   input logic        seq_wait,
   input logic        div_fin
);
   function automatic logic [15:0] step_mask(input logic [2:0] p);
      if (p >= 3'd6) return 16'h0;
      else           return (16'h1 << (3'd6 - p)) - 16'h1;
   endfunction

   // R2: done is a single-cycle pulse
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: result words move only together with done
   a_r2_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(word_a) && $stable(word_b)));

   // R9: on threshold never above off threshold
   a_r9_on_below_off: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (word_a[31:16] <= word_a[15:0]));

   // R8: on threshold is a multiple of the precision step
   a_r8_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((word_a[31:16] & step_mask(word_b[22:20])) == 16'h0));

   // R10: clocks per word is at least one
   a_r10_xclk_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (word_b[15:0] != 16'h0));

   // R11: the shared divider completes only while the sequencer waits on it
   a_r11_div_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
      div_fin |-> seq_wait);
endmodule

bind dft_calc dft_calc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .word_a(word_a), .word_b(word_b),
   .seq_wait(seq_wait), .div_fin(dv_fin)
);

// File: tb/tb_dft_calc.sv
`timescale 1ns/1ps
module tb_dft_calc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  mem_fb_div = '0, pix_fb_div = '0;
   logic [3:0]  pix_post_real = '0;
   logic [1:0]  mem_ref_div = '0, mem_post_code = '0;
   logic [5:0]  pix_bpp = '0, fifo_depth = '0;
   logic [4:0]  ras_delay = '0, page_delay = '0;
   logic [3:0]  loop_latency = '0;
   logic        done;
   logic [31:0] word_a, word_b;

   always #2.5 clk = ~clk;

   dft_calc dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mem_fb_div(mem_fb_div), .pix_fb_div(pix_fb_div), .pix_post_real(pix_post_real),
      .mem_ref_div(mem_ref_div), .mem_post_code(mem_post_code), .pix_bpp(pix_bpp),
      .fifo_depth(fifo_depth), .ras_delay(ras_delay), .page_delay(page_delay),
      .loop_latency(loop_latency), .done(done), .word_a(word_a), .word_b(word_b)
   );

   int     n_checks = 0, n_fail = 0, extra_done = 0;
   longint cyc = 0, start_cyc = 0;
   bit     mon_on = 1'b0, prev_done = 1'b0, finished = 1'b0;
   logic [31:0] last_a = '0, last_b = '0;
   longint exp_a_q[$], exp_b_q[$];
   bit     cl_q[$];
   string  tag_q[$];

   task automatic chk(input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic report();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   function automatic longint lsh(input longint v, input longint a);
      if (a >= 0) return v << a;
      else        return v >>> (-a);
   endfunction

   function automatic bit ref_calc(input longint mfb, vfb, vp, xr, code, bpp, fifo, ras, pf, lat,
                                   output longint ea, output longint eb, output bit cl);
      longint m, d, s, t, p, xs, s2, off, onv, r, st, offd, x, tmp;
      ea = 0; eb = 0; cl = 1'b0;
      m = mfb * vp;
      d = vfb * xr;
      if (bpp >= 8) d = d * (bpp / 4);
      s = 4 - code;
      if (bpp == 0) s = s - 1;
      if (m == 0 || d == 0 || s < 0 || fifo < 2) return 1'b0;
      while ((m % 2 == 0) && (d % 2 == 0)) begin m = m / 2; d = d / 2; end
      t = lsh(m * fifo, s) / d;
      p = -5;
      while (t > 0) begin t = t / 2; p++; end
      if (p < 0) p = 0;
      if (p > 7) p = 7;
      xs = 6 - p;
      s2 = s + xs;
      off = lsh(m * (fifo - 1), s2) / d - (longint'(1) << s);
      onv = (lsh(m, s2) + d) / d;
      r = lsh(ras, xs) + 1;
      if (onv < r) onv = r;
      onv = onv + 2 * r + lsh(pf, xs);
      st = (((longint'(1) << (7 - p)) - 1) >> 1) + 1;
      onv = ((onv + st - 1) / st) * st;
      if (off < 0) return 1'b0;
      offd = (off / st) * st;
      if (onv >= offd) begin
         tmp = off - lsh(m, s2) / d;
         if (tmp < 0) return 1'b0;
         onv = (tmp / st) * st;
         cl = 1'b1;
      end
      x = (lsh(m, s2 + 5) + d) / d;
      if (off > 65535 || onv > 65535 || x > 65535) return 1'b0;
      ea = (onv << 16) | off;
      eb = (p << 20) | (lat << 16) | x;
      return 1'b1;
   endfunction

   task automatic drive(input int mfb, vfb, vp, xr, code, bpp, fifo, ras, pf, lat);
      @(negedge clk);
      mem_fb_div = 8'(mfb); pix_fb_div = 8'(vfb); pix_post_real = 4'(vp);
      mem_ref_div = 2'(xr); mem_post_code = 2'(code); pix_bpp = 6'(bpp);
      fifo_depth = 6'(fifo); ras_delay = 5'(ras); page_delay = 5'(pf);
      loop_latency = 4'(lat);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (exp_a_q.size() != 0 && guard < 400) begin @(negedge clk); guard++; end
      chk("R11 result arrived", longint'(exp_a_q.size()), 0);
   endtask

   task automatic run_case(input string tag, input int mfb, vfb, vp, xr, code, bpp, fifo, ras, pf, lat,
                           input bit hold_open);
      longint ea, eb;
      bit cl;
      if (!ref_calc(mfb, vfb, vp, xr, code, bpp, fifo, ras, pf, lat, ea, eb, cl)) return;
      exp_a_q.push_back(ea); exp_b_q.push_back(eb); cl_q.push_back(cl); tag_q.push_back(tag);
      start_cyc = cyc + 1;
      drive(mfb, vfb, vp, xr, code, bpp, fifo, ras, pf, lat);
      if (!hold_open) wait_idle();
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !finished) begin
         n_checks++; n_fail++;
         $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 150000);
         report();
      end
   end

   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (done) begin
            chk("R2 done single pulse", longint'(prev_done), 0);
            if (exp_a_q.size() == 0) begin
               extra_done++;
               chk("R3 unexpected done", 1, 0);
            end else begin
               longint ea, eb;
               bit cl;
               string tg;
               ea = exp_a_q.pop_front(); eb = exp_b_q.pop_front();
               cl = cl_q.pop_front(); tg = tag_q.pop_front();
               chk({tg, " off R7"}, longint'(word_a[15:0]), ea & 16'hFFFF);
               chk({tg, (cl ? " on fallback R9" : " on rounded R8")}, longint'(word_a[31:16]), (ea >> 16) & 16'hFFFF);
               chk({tg, " precision R6"}, longint'(word_b[22:20]), (eb >> 20) & 7);
               chk({tg, " loop latency R10"}, longint'(word_b[19:16]), (eb >> 16) & 15);
               chk({tg, " clocks per word R10"}, longint'(word_b[15:0]), eb & 16'hFFFF);
               chk({tg, " upper bits R10"}, longint'(word_b[31:23]), 0);
               chk({tg, " latency R11"}, longint'((cyc - start_cyc) <= 240), 1);
            end
         end else begin
            chk("R2 word_a held", longint'(word_a), longint'(last_a));
            chk("R2 word_b held", longint'(word_b), longint'(last_b));
         end
         prev_done = done;
         last_a = word_a;
         last_b = word_b;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 done in reset", longint'(done), 0);
      chk("R1 word_a in reset", longint'(word_a), 0);
      chk("R1 word_b in reset", longint'(word_b), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 done after reset", longint'(done), 0);
      chk("R1 word_a after reset", longint'(word_a), 0);
      chk("R1 word_b after reset", longint'(word_b), 0);
      mon_on = 1'b1;

      run_case("R4 base 32bpp", 150, 200, 2, 1, 1, 32, 32, 7, 6, 10, 1'b0);
      run_case("R9 large delays", 150, 200, 2, 1, 1, 32, 32, 31, 31, 10, 1'b0);
      run_case("R5 text mode", 180, 180, 1, 1, 1, 0, 24, 5, 4, 11, 1'b0);
      run_case("R4 24bpp ref3", 170, 190, 3, 3, 2, 24, 32, 8, 7, 8, 1'b0);
      run_case("R6 top precision", 200, 150, 12, 1, 0, 8, 32, 7, 6, 9, 1'b0);
      run_case("R6 zero precision", 130, 250, 1, 1, 3, 32, 24, 3, 2, 12, 1'b0);

      foreach (tag_q[i]) begin end
      for (int vi = 0; vi < 8; vi++) begin
         int vps[8] = '{1, 2, 3, 4, 5, 6, 8, 12};
         for (int bi = 0; bi < 4; bi++) begin
            int bpps[4] = '{0, 8, 16, 32};
            for (int fi = 0; fi < 2; fi++) begin
               run_case("R4 sweep", 160, 200, vps[vi], 1, 1, bpps[bi], (fi == 0) ? 24 : 32,
                        6, 5, 9, 1'b0);
            end
         end
      end

      // R3: a second start while busy carries other operands and must change nothing
      run_case("R3 first operands", 150, 200, 2, 1, 1, 16, 32, 6, 5, 7, 1'b1);
      repeat (20) @(negedge clk);
      drive(220, 140, 5, 3, 0, 8, 24, 9, 9, 3);
      wait_idle();
      repeat (300) @(negedge clk);
      chk("R3 no extra done", longint'(extra_done), 0);

      report();
   end
endmodule